// File: doc/BRIEF.md
# Single-Cycle 4-Bit Processor Core

This block is a compact processor core that executes one 16-bit instruction per clock over a 4-bit datapath. It holds a program counter, a word-addressed instruction store, a sixteen-entry register file whose entry 0 is fixed at zero, an ALU that raises a zero flag, a sixteen-word data store of 4-bit words and a combinational decoder. Each instruction word carries a 4-bit opcode in its top nibble and three 4-bit fields below it. Register, immediate, shift, load/store, branch-on-equal and absolute-jump operations are supported. Every value wraps modulo 16.

The instruction store is filled through a write port while reset is held. Software builds a stack on any register used as a stack pointer. Register 7 is the convention. A push is a decrement of that register followed by a store at offset 0. A pop is a load at offset 0 followed by an increment. The core exposes its program counter and the register and data-store write strobes of the instruction currently executing, so that its progress can be observed at the ports.

Top module: `cpu4_core`

## Requirements
- R1: While rst_ni is low the program counter reads 0, and every register and data-store word is cleared, so a register read after reset returns 0.
- R2: Every instruction except a taken branch or a jump advances the program counter by exactly 1 on the next clock.
- R3: Opcodes 0..3 (add, sub, and, or) write source1 op source2 into the register in bits [3:0]. Source1 is in bits [11:8] and source2 is in bits [7:4]. Add and sub wrap modulo 16.
- R4: Opcodes 4 (addi) and 5 (subi) write source [11:8] plus or minus the zero-extended immediate [3:0] into the register in bits [7:4], modulo 16.
- R5: Opcodes 6 (sll) and 7 (srl) shift register [11:8] by the amount in bits [3:0] and write the result to register [7:4]. An amount of 4 or more gives 0.
- R6: Register 0 always reads as 0. A write to it is issued at the write strobe but changes nothing.
- R7: Opcode 8 (lw) loads data[reg[11:8] + imm[3:0]] into register [7:4]. Opcode 9 (sw) stores register [7:4] there without writing any register. The address wraps modulo 16.
- R8: Push (subi then sw) and pop (lw then addi) on a stack register work in last-in-first-out order, including when the pointer wraps from 0 to 15.
- R9: Opcode 10 (beq) sets PC to PC+1+imm when registers [11:8] and [7:4] are equal, and to PC+1 otherwise. Here imm is bits [3:0] read as signed two's complement.
- R10: Opcode 11 (j) loads the program counter with the low PC_W bits of the 8-bit target in bits [11:4].
- R11: Opcodes 12..15 write neither registers nor data and only advance the program counter.
- R12: A word written through the instruction write port at an address is the instruction executed when the program counter holds that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction store write enable |
| imem_addr_i | input | PC_W | Instruction store write address |
| imem_wdata_i | input | 16 | Instruction word to write |
| pc_o | output | PC_W | Address of the executing instruction |
| rf_we_o | output | 1 | Register write strobe of the current instruction |
| rf_waddr_o | output | 4 | Register being written |
| rf_wdata_o | output | DATA_W | Value being written to the register |
| dm_we_o | output | 1 | Data-store write strobe of the current instruction |
| dm_addr_o | output | DATA_W | Data-store address being written |
| dm_wdata_o | output | DATA_W | Value being stored |

## Verification
A register that holds a wrong value usually shows up on the very next instruction that reads it. It appears as a wrong write value, a wrong store address or a wrong branch outcome in the same cycle as that read. A wrong next-PC choice shows one clock later as an unexpected program counter, and every later step then drifts. For this reason the bench compares the program counter and both write strobes on every executed cycle, not only at the end of a program. Stack wrap, shift saturation, backward branches and jump truncation are each placed where a fault would change a later write.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;
  localparam int unsigned ILEN  = 16;
  localparam int unsigned FLD_W = 4;
  localparam int unsigned NREG  = 2 ** FLD_W;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_ADDI = 4'd4,
    OP_SUBI = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_LW   = 4'd8,
    OP_SW   = 4'd9,
    OP_BEQ  = 4'd10,
    OP_J    = 4'd11
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLL,
    ALU_SRL
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    b_imm;    // operand b from bits [3:0]
    logic    rf_we;
    logic    wb_mem;   // write back load data
    logic    dm_we;
    logic    rd_low;   // destination in bits [3:0]
    logic    is_beq;
    logic    is_j;
  } ctrl_t;
endpackage

// File: rtl/cpu4_alu.sv
module cpu4_alu
  import cpu4_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o,
  output logic              zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLL: y_o = a_i << b_i;
      ALU_SRL: y_o = a_i >> b_i;
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/cpu4_decoder.sv
module cpu4_decoder
  import cpu4_pkg::*;
(
  input  logic [3:0] opcode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{alu_op: ALU_ADD, default: 1'b0};
    unique case (opcode_i)
      OP_ADD:  begin ctrl_o.rf_we = 1'b1; ctrl_o.rd_low = 1'b1; end
      OP_SUB:  begin ctrl_o.rf_we = 1'b1; ctrl_o.rd_low = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      OP_AND:  begin ctrl_o.rf_we = 1'b1; ctrl_o.rd_low = 1'b1; ctrl_o.alu_op = ALU_AND; end
      OP_OR:   begin ctrl_o.rf_we = 1'b1; ctrl_o.rd_low = 1'b1; ctrl_o.alu_op = ALU_OR;  end
      OP_ADDI: begin ctrl_o.rf_we = 1'b1; ctrl_o.b_imm = 1'b1; end
      OP_SUBI: begin ctrl_o.rf_we = 1'b1; ctrl_o.b_imm = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      OP_SLL:  begin ctrl_o.rf_we = 1'b1; ctrl_o.b_imm = 1'b1; ctrl_o.alu_op = ALU_SLL; end
      OP_SRL:  begin ctrl_o.rf_we = 1'b1; ctrl_o.b_imm = 1'b1; ctrl_o.alu_op = ALU_SRL; end
      OP_LW:   begin ctrl_o.rf_we = 1'b1; ctrl_o.b_imm = 1'b1; ctrl_o.wb_mem = 1'b1; end
      OP_SW:   begin ctrl_o.dm_we = 1'b1; ctrl_o.b_imm = 1'b1; end
      OP_BEQ:  begin ctrl_o.is_beq = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      OP_J:    ctrl_o.is_j = 1'b1;
      default: ;  // 12..15: no operation
    endcase
  end
endmodule

// File: rtl/cpu4_regfile.sv
module cpu4_regfile #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned NREG   = 16,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_data_o = (ra_addr_i == '0) ? '0 : regs_q[ra_addr_i];
  assign rb_data_o = (rb_addr_i == '0) ? '0 : regs_q[rb_addr_i];
endmodule

// File: rtl/cpu4_dmem.sv
module cpu4_dmem #(
  parameter int unsigned DATA_W = 4,
  localparam int unsigned DEPTH = 2 ** DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
  import cpu4_pkg::*;
#(
  parameter int unsigned PC_W   = 5,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned IDEPTH = 2 ** PC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              imem_we_i,
  input  logic [PC_W-1:0]   imem_addr_i,
  input  logic [ILEN-1:0]   imem_wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              rf_we_o,
  output logic [FLD_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              dm_we_o,
  output logic [DATA_W-1:0] dm_addr_o,
  output logic [DATA_W-1:0] dm_wdata_o
);
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [ILEN-1:0]   imem [IDEPTH];
  logic [ILEN-1:0]   instr;
  logic [FLD_W-1:0]  ra_addr, rb_addr, imm;
  logic [DATA_W-1:0] ra_data, rb_data, alu_b, alu_y, dm_rdata;
  logic              alu_zero;
  ctrl_t             ctrl;

  // instruction store: loaded through the write port, read combinationally
  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_addr_i] <= imem_wdata_i;
  end

  assign instr   = imem[pc_q];
  assign ra_addr = instr[11:8];
  assign rb_addr = instr[7:4];
  assign imm     = instr[3:0];

  cpu4_decoder u_dec (
    .opcode_i (instr[15:12]),
    .ctrl_o   (ctrl)
  );

  cpu4_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (ra_addr),
    .ra_data_o (ra_data),
    .rb_addr_i (rb_addr),
    .rb_data_o (rb_data),
    .we_i      (rf_we_o),
    .waddr_i   (rf_waddr_o),
    .wdata_i   (rf_wdata_o)
  );

  assign alu_b = ctrl.b_imm ? DATA_W'(imm) : rb_data;

  cpu4_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (ctrl.alu_op),
    .a_i    (ra_data),
    .b_i    (alu_b),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  cpu4_dmem #(.DATA_W(DATA_W)) u_dm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dm_we_o),
    .addr_i  (alu_y),
    .wdata_i (rb_data),
    .rdata_o (dm_rdata)
  );

  assign rf_we_o    = ctrl.rf_we;
  assign rf_waddr_o = ctrl.rd_low ? instr[3:0] : instr[7:4];
  assign rf_wdata_o = ctrl.wb_mem ? dm_rdata : alu_y;
  assign dm_we_o    = ctrl.dm_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rb_data;

  // next PC: sequential, signed branch offset, or truncated absolute target
  logic [PC_W-1:0] pc_inc, br_off;
  assign pc_inc = pc_q + 1'b1;
  assign br_off = {{(PC_W-FLD_W){imm[FLD_W-1]}}, imm};

  always_comb begin
    pc_d = pc_inc;
    if (ctrl.is_j)                  pc_d = instr[4 +: PC_W];
    else if (ctrl.is_beq && alu_zero) pc_d = pc_inc + br_off;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/cpu4_core_chk.sv
module cpu4_core_chk #(
  parameter int unsigned PC_W   = 5,
  parameter int unsigned DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       instr_i,
  input logic [PC_W-1:0]   pc_i,
  input logic              rf_we_i,
  input logic              dm_we_i,
  input logic [3:0]        ra_addr_i,
  input logic [DATA_W-1:0] ra_data_i,
  input logic [DATA_W-1:0] rb_data_i
);
  logic [3:0]      op;
  logic [PC_W-1:0] br_tgt;
  assign op     = instr_i[15:12];
  assign br_tgt = pc_i + 1'b1 + {{(PC_W-4){instr_i[3]}}, instr_i[3:0]};

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_pc_reset: assert (pc_i == '0);
  end

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 4'd10 && op != 4'd11) |=> (pc_i == PC_W'($past(pc_i) + 1'b1)));

  a_r6_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == 4'd0) |-> (ra_data_i == '0));

  a_r7_store_no_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we_i |-> !rf_we_i);

  a_r9_beq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'd10 && ra_data_i == rb_data_i) |=> (pc_i == $past(br_tgt)));

  a_r10_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'd11) |=> (pc_i == $past(instr_i[4 +: PC_W])));

  a_r11_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op >= 4'd12) |-> (!rf_we_i && !dm_we_i));
endmodule

bind cpu4_core cpu4_core_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .instr_i   (instr),
  .pc_i      (pc_q),
  .rf_we_i   (rf_we_o),
  .dm_we_i   (dm_we_o),
  .ra_addr_i (ra_addr),
  .ra_data_i (ra_data),
  .rb_data_i (rb_data)
);

// File: tb/cpu4_core_tb.sv
`timescale 1ns/1ps
module cpu4_core_tb;
  localparam int PC_W = 5;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            imem_we_i = 1'b0;
  logic [PC_W-1:0] imem_addr_i = '0;
  logic [15:0]     imem_wdata_i = '0;
  logic [PC_W-1:0] pc_o;
  logic            rf_we_o, dm_we_o;
  logic [3:0]      rf_waddr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;

  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cpu4_core #(.PC_W(PC_W), .DATA_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_we_i(imem_we_i), .imem_addr_i(imem_addr_i), .imem_wdata_i(imem_wdata_i),
    .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  typedef struct {
    int pc;
    bit rf_we; int rf_a; int rf_d;
    bit dm_we; int dm_a; int dm_d;
  } step_t;

  step_t exq[$];
  string tagq[$];

  task automatic push(int pc, bit rwe, int ra, int rd, bit dwe, int da, int dd, string tag);
    step_t s;
    s.pc = pc; s.rf_we = rwe; s.rf_a = ra; s.rf_d = rd;
    s.dm_we = dwe; s.dm_a = da; s.dm_d = dd;
    exq.push_back(s);
    tagq.push_back(tag);
  endtask

  task automatic ex_rf(int pc, int a, int d, string tag);
    push(pc, 1'b1, a, d, 1'b0, 0, 0, tag);
  endtask
  task automatic ex_dm(int pc, int a, int d, string tag);
    push(pc, 1'b0, 0, 0, 1'b1, a, d, tag);
  endtask
  task automatic ex_none(int pc, string tag);
    push(pc, 1'b0, 0, 0, 1'b0, 0, 0, tag);
  endtask

  // monitor: one expected step per executed cycle, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_en && rst_ni && exq.size() > 0) begin
      step_t e;
      string t;
      bit bad;
      e = exq.pop_front();
      t = tagq.pop_front();
      bad = (int'(pc_o) != e.pc) || (rf_we_o != e.rf_we) || (dm_we_o != e.dm_we);
      if (e.rf_we && (int'(rf_waddr_o) != e.rf_a || int'(rf_wdata_o) != e.rf_d)) bad = 1'b1;
      if (e.dm_we && (int'(dm_addr_o) != e.dm_a || int'(dm_wdata_o) != e.dm_d)) bad = 1'b1;
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL %s: actual pc=%0d rf=%0b/%0d/%0d dm=%0b/%0d/%0d expected pc=%0d rf=%0b/%0d/%0d dm=%0b/%0d/%0d",
                 t, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, dm_we_o, dm_addr_o, dm_wdata_o,
                 e.pc, e.rf_we, e.rf_a, e.rf_d, e.dm_we, e.dm_a, e.dm_d);
      end
    end
  end

  task automatic load(int a, logic [15:0] w);
    @(negedge clk);
    imem_we_i = 1'b1; imem_addr_i = PC_W'(a); imem_wdata_i = w;
  endtask

  task automatic start_phase();
    @(negedge clk);
    rst_ni = 1'b0;
    mon_en = 1'b0;
  endtask

  task automatic run_phase();
    @(negedge clk);
    imem_we_i = 1'b0;
    checks++;
    if (pc_o != '0) begin
      failures++;
      $display("FAIL R1: actual pc=%0d expected pc=0 in reset", pc_o);
    end
    @(posedge clk);
    #2 rst_ni = 1'b1;
    mon_en = 1'b1;
    wait (exq.size() == 0);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);

    // Program A: R3 R4 R5 R6 R11 R12
    start_phase();
    load(0, 16'h4015); load(1, 16'h402C); load(2, 16'h0123); load(3, 16'h1124);
    load(4, 16'h2125); load(5, 16'h3123); load(6, 16'h6141); load(7, 16'h7252);
    load(8, 16'h6144); load(9, 16'h5116); load(10, 16'h0120); load(11, 16'h0003);
    load(12, 16'hC123); load(13, 16'hFFFF); load(14, 16'hB0E0);
    ex_rf(0, 1, 5, "R4 addi");
    ex_rf(1, 2, 12, "R4 addi");
    ex_rf(2, 3, 1, "R3 add wrap");
    ex_rf(3, 4, 9, "R3 sub wrap");
    ex_rf(4, 5, 4, "R3 and");
    ex_rf(5, 3, 13, "R3 or");
    ex_rf(6, 4, 10, "R5 sll");
    ex_rf(7, 5, 3, "R5 srl");
    ex_rf(8, 4, 0, "R5 shift by 4");
    ex_rf(9, 1, 15, "R4 subi wrap");
    ex_rf(10, 0, 11, "R6 write r0 strobe");
    ex_rf(11, 3, 0, "R6 r0 still zero");
    ex_none(12, "R11 opcode 12");
    ex_none(13, "R11 opcode 15");
    ex_none(14, "R12 jump self");
    ex_none(14, "R12 jump self");
    run_phase();

    // Program B: R7 R8 R1 (stack wrap, offsets)
    start_phase();
    load(0, 16'h4019); load(1, 16'h4026); load(2, 16'h5771); load(3, 16'h9710);
    load(4, 16'h5771); load(5, 16'h9720); load(6, 16'h8730); load(7, 16'h4771);
    load(8, 16'h8740); load(9, 16'h4771); load(10, 16'h9213); load(11, 16'h8059);
    load(12, 16'h912F); load(13, 16'h8060); load(14, 16'hB0E0);
    ex_rf(0, 1, 9, "R4 setup");
    ex_rf(1, 2, 6, "R4 setup");
    ex_rf(2, 7, 15, "R8 push dec wrap");
    ex_dm(3, 15, 9, "R8 push store");
    ex_rf(4, 7, 14, "R8 push dec");
    ex_dm(5, 14, 6, "R8 push store");
    ex_rf(6, 3, 6, "R8 pop load lifo");
    ex_rf(7, 7, 15, "R8 pop inc");
    ex_rf(8, 4, 9, "R8 pop load");
    ex_rf(9, 7, 0, "R8 pop inc wrap");
    ex_dm(10, 9, 9, "R7 sw base+off");
    ex_rf(11, 5, 9, "R7 lw base+off");
    ex_dm(12, 8, 6, "R7 sw address wrap");
    ex_rf(13, 6, 0, "R1 data store cleared");
    ex_none(14, "R2 jump self");
    run_phase();

    // Program C: R9 R10 R2 R1 (branches, loop, truncated jump)
    start_phase();
    load(0, 16'h4013); load(1, 16'h4023); load(2, 16'hA122); load(3, 16'h4031);
    load(4, 16'h4032); load(5, 16'hA103); load(6, 16'hB090); load(7, 16'h4031);
    load(8, 16'h4031); load(9, 16'h5111); load(10, 16'hA101); load(11, 16'hB090);
    load(12, 16'h0456); load(13, 16'hB8E0); load(14, 16'hA00F);
    ex_rf(0, 1, 3, "R2 seq");
    ex_rf(1, 2, 3, "R2 seq");
    ex_none(2, "R9 beq taken fwd");
    ex_none(5, "R9 beq not taken");
    ex_none(6, "R10 jump");
    ex_rf(9, 1, 2, "R4 loop dec");
    ex_none(10, "R9 not taken");
    ex_none(11, "R10 jump back");
    ex_rf(9, 1, 1, "R4 loop dec");
    ex_none(10, "R9 not taken");
    ex_none(11, "R10 jump back");
    ex_rf(9, 1, 0, "R4 loop dec");
    ex_none(10, "R9 taken exit");
    ex_rf(12, 6, 0, "R1 registers cleared");
    ex_none(13, "R10 truncated target");
    ex_none(14, "R9 backward offset");
    ex_none(14, "R9 backward offset");
    run_phase();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule